// File: doc/BRIEF.md
# Direct-Mode DMA Channel

This block is a single DMA channel that runs without descriptors. Software loads a source address, a destination address and a byte count into registers, then launches the move by taking the start bit of the mode register from 0 to 1. The channel then alternates read and write requests on a simple memory request interface. Each read fetches a chunk from the source and the matching write stores it at the destination. The registers advance after every chunk until the count reaches zero.

An abort edge stops the channel at once. If a request completes with an error, the channel halts and keeps the remaining count and addresses, so software can resume it with a continue edge. One interrupt line reports end of segment and error, each gated by its own enable bit. After reset the channel sits idle in direct mode.

Register map, selected by `reg_addr_i`: 0 mode, 1 status, 2 source address, 3 destination address, 4 byte count. Mode bits: [0] start, [1] abort, [2] continue, [3] end-of-segment interrupt enable, [4] error interrupt enable. Status bits: [0] busy, [1] error (W1C), [2] end of segment (W1C), [3] halted.

Top module: `dma_direct_chan`

## Requirements
- R1: After reset every register reads 0, no request is issued and `irq_o` is low.
- R2: A transfer begins only when a mode write takes bit 0 from 0 to 1. Writing bit 0 as 1 while it already holds 1 starts nothing.
- R3: Status bit 0 (busy) is 1 from the start edge until the last write completes, and 0 afterwards. A request is issued only while busy.
- R4: Each chunk is a read at the source address followed by a write at the destination address, with the same length. `mem_we_o` is 1 for the write. The length is 32 bytes, or the remaining count if that is smaller. After each write, both addresses advance by the length and the count drops by it.
- R5: On completion, status bit 2 is set. `irq_o` follows it only when mode bit 3 is 1.
- R6: A start with a byte count of 0 sets status bit 2 without issuing any request.
- R7: A mode write that takes bit 1 from 0 to 1 while busy drops the request and clears busy, and does not set status bit 2. It takes priority over an acknowledge in the same cycle, and the chunk in flight is not credited to the addresses or the count.
- R8: An acknowledge with `mem_err_i` high halts the channel. Busy clears, status bits 1 and 3 are set, and addresses and count stay at the last credited chunk. `irq_o` rises when mode bit 4 is 1.
- R9: Writing 1 to status bit 1 or bit 2 clears that flag. Writing 0 leaves it unchanged.
- R10: A mode write that takes bit 2 from 0 to 1 while halted resumes the transfer from the remaining count and addresses, and clears the halted bit.
- R11: Writes to the source, destination and count registers are ignored while busy.
- R12: A request holds its kind, address and length stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index |
| reg_wdata_i | input | RW | Register write data |
| reg_rdata_o | output | RW | Register read data (combinational) |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | 1 = write to destination, 0 = read from source |
| mem_addr_o | output | RW | Request byte address |
| mem_len_o | output | LW | Request length in bytes |
| mem_ack_i | input | 1 | Request completed |
| mem_err_i | input | 1 | Completion carries an error (valid with ack) |
| irq_o | output | 1 | Enabled end-of-segment or error interrupt |

## Verification
An abort write and the acknowledge of an outstanding write can land in the same clock edge. The bench provokes this by driving the abort edge on the mode register and raising `mem_ack_i` in the same cycle, while a chunk's write is pending. It then judges the outcome at the ports: the request must be gone, the busy and end-of-segment flags must read 0, and the count and source registers must still hold their pre-chunk values. That shows the abort won and nothing was credited.

// File: rtl/dma_direct_pkg.sv
package dma_direct_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_HALT} chan_st_e;

  localparam logic [2:0] OFS_MODE = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd1;
  localparam logic [2:0] OFS_SRC  = 3'd2;
  localparam logic [2:0] OFS_DST  = 3'd3;
  localparam logic [2:0] OFS_CNT  = 3'd4;

  localparam int MODE_W   = 5;
  localparam int MB_START = 0;
  localparam int MB_ABORT = 1;
  localparam int MB_CONT  = 2;
  localparam int MB_EOSIE = 3;
  localparam int MB_ERRIE = 4;

  localparam int SB_ERR = 1;
  localparam int SB_EOS = 2;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_direct_pkg::*;
#(
  parameter int RW = 32,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [2:0]    addr_i,
  input  logic [RW-1:0] wdata_i,
  output logic [RW-1:0] rdata_o,
  input  logic          busy_i,
  input  logic          halted_i,
  input  logic          adv_i,
  input  logic [CW-1:0] adv_len_i,
  input  logic          eos_set_i,
  input  logic          err_set_i,
  output logic          start_p_o,
  output logic          abort_p_o,
  output logic          cont_p_o,
  output logic [RW-1:0] src_o,
  output logic [RW-1:0] dst_o,
  output logic [CW-1:0] cnt_o,
  output logic          err_o,
  output logic          eos_o,
  output logic          irq_o
);
  logic [MODE_W-1:0] mode_q;
  logic [RW-1:0]     src_q, dst_q;
  logic [CW-1:0]     cnt_q;
  logic              err_q, eos_q;
  logic              mode_wr, stat_wr;

  assign mode_wr = we_i && (addr_i == OFS_MODE);
  assign stat_wr = we_i && (addr_i == OFS_STAT);

  // edge pulses: new value 1 while stored value 0
  assign start_p_o = mode_wr && wdata_i[MB_START] && !mode_q[MB_START];
  assign abort_p_o = mode_wr && wdata_i[MB_ABORT] && !mode_q[MB_ABORT];
  assign cont_p_o  = mode_wr && wdata_i[MB_CONT]  && !mode_q[MB_CONT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      err_q  <= 1'b0;
      eos_q  <= 1'b0;
    end else begin
      if (mode_wr) mode_q <= wdata_i[MODE_W-1:0];
      if (adv_i) begin
        src_q <= src_q + RW'(adv_len_i);
        dst_q <= dst_q + RW'(adv_len_i);
        cnt_q <= cnt_q - adv_len_i;
      end else if (we_i && !busy_i) begin
        case (addr_i)
          OFS_SRC: src_q <= wdata_i;
          OFS_DST: dst_q <= wdata_i;
          OFS_CNT: cnt_q <= wdata_i[CW-1:0];
          default: ;
        endcase
      end
      err_q <= err_set_i || (err_q && !(stat_wr && wdata_i[SB_ERR]));
      eos_q <= eos_set_i || (eos_q && !(stat_wr && wdata_i[SB_EOS]));
    end
  end

  always_comb begin
    case (addr_i)
      OFS_MODE: rdata_o = RW'(mode_q);
      OFS_STAT: rdata_o = RW'({halted_i, eos_q, err_q, busy_i});
      OFS_SRC:  rdata_o = src_q;
      OFS_DST:  rdata_o = dst_q;
      OFS_CNT:  rdata_o = RW'(cnt_q);
      default:  rdata_o = '0;
    endcase
  end

  assign src_o = src_q;
  assign dst_o = dst_q;
  assign cnt_o = cnt_q;
  assign err_o = err_q;
  assign eos_o = eos_q;
  assign irq_o = (eos_q && mode_q[MB_EOSIE]) || (err_q && mode_q[MB_ERRIE]);
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_direct_pkg::*;
#(
  parameter int RW        = 32,
  parameter int CW        = 16,
  parameter int MAX_BURST = 32,
  parameter int LW        = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_p_i,
  input  logic          abort_p_i,
  input  logic          cont_p_i,
  input  logic [RW-1:0] src_i,
  input  logic [RW-1:0] dst_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          mem_ack_i,
  input  logic          mem_err_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [RW-1:0] mem_addr_o,
  output logic [LW-1:0] mem_len_o,
  output logic          busy_o,
  output logic          halted_o,
  output logic          adv_o,
  output logic [CW-1:0] adv_len_o,
  output logic          eos_set_o,
  output logic          err_set_o
);
  chan_st_e      st_q, st_d;
  logic          last;
  logic [LW-1:0] chunk;

  assign last  = cnt_i <= CW'(MAX_BURST);
  assign chunk = last ? cnt_i[LW-1:0] : LW'(MAX_BURST);

  always_comb begin
    st_d      = st_q;
    adv_o     = 1'b0;
    eos_set_o = 1'b0;
    err_set_o = 1'b0;
    case (st_q)
      ST_IDLE, ST_HALT: begin
        if (st_q == ST_HALT && abort_p_i) begin
          st_d = ST_IDLE;
        end else if (start_p_i || (cont_p_i && st_q == ST_HALT)) begin
          if (cnt_i == '0) begin
            eos_set_o = 1'b1;
            st_d      = ST_IDLE;
          end else begin
            st_d = ST_RD;
          end
        end
      end
      ST_RD, ST_WR: begin
        if (abort_p_i) begin
          st_d = ST_IDLE;
        end else if (mem_ack_i) begin
          if (mem_err_i) begin
            err_set_o = 1'b1;
            st_d      = ST_HALT;
          end else if (st_q == ST_RD) begin
            st_d = ST_WR;
          end else begin
            adv_o = 1'b1;
            if (last) begin
              eos_set_o = 1'b1;
              st_d      = ST_IDLE;
            end else begin
              st_d = ST_RD;
            end
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign mem_req_o  = (st_q == ST_RD) || (st_q == ST_WR);
  assign mem_we_o   = (st_q == ST_WR);
  assign mem_addr_o = (st_q == ST_WR) ? dst_i : src_i;
  assign mem_len_o  = chunk;
  assign busy_o     = mem_req_o;
  assign halted_o   = (st_q == ST_HALT);
  assign adv_len_o  = CW'(chunk);
endmodule

// File: rtl/dma_direct_chan.sv
module dma_direct_chan #(
  parameter int RW        = 32,
  parameter int CW        = 16,
  parameter int MAX_BURST = 32,
  localparam int LW       = $clog2(MAX_BURST) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [RW-1:0] reg_wdata_i,
  output logic [RW-1:0] reg_rdata_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [RW-1:0] mem_addr_o,
  output logic [LW-1:0] mem_len_o,
  input  logic          mem_ack_i,
  input  logic          mem_err_i,
  output logic          irq_o
);
  logic          busy_w, halted_w, adv_w, eos_set_w, err_set_w;
  logic          start_p_w, abort_p_w, cont_p_w, err_w, eos_w;
  logic [RW-1:0] src_w, dst_w;
  logic [CW-1:0] cnt_w, adv_len_w;

  dma_chan_regs #(.RW(RW), .CW(CW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .busy_i    (busy_w),
    .halted_i  (halted_w),
    .adv_i     (adv_w),
    .adv_len_i (adv_len_w),
    .eos_set_i (eos_set_w),
    .err_set_i (err_set_w),
    .start_p_o (start_p_w),
    .abort_p_o (abort_p_w),
    .cont_p_o  (cont_p_w),
    .src_o     (src_w),
    .dst_o     (dst_w),
    .cnt_o     (cnt_w),
    .err_o     (err_w),
    .eos_o     (eos_w),
    .irq_o     (irq_o)
  );

  dma_chan_seq #(.RW(RW), .CW(CW), .MAX_BURST(MAX_BURST), .LW(LW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_p_i  (start_p_w),
    .abort_p_i  (abort_p_w),
    .cont_p_i   (cont_p_w),
    .src_i      (src_w),
    .dst_i      (dst_w),
    .cnt_i      (cnt_w),
    .mem_ack_i  (mem_ack_i),
    .mem_err_i  (mem_err_i),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_len_o  (mem_len_o),
    .busy_o     (busy_w),
    .halted_o   (halted_w),
    .adv_o      (adv_w),
    .adv_len_o  (adv_len_w),
    .eos_set_o  (eos_set_w),
    .err_set_o  (err_set_w)
  );
endmodule

// File: rtl/dma_direct_chan_chk.sv
module dma_direct_chan_chk #(
  parameter int RW        = 32,
  parameter int CW        = 16,
  parameter int MAX_BURST = 32,
  parameter int LW        = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [RW-1:0] mem_addr_o,
  input logic [LW-1:0] mem_len_o,
  input logic          mem_ack_i,
  input logic          mem_err_i,
  input logic          busy,
  input logic          adv,
  input logic          abort_p,
  input logic [CW-1:0] cnt,
  input logic          err_f,
  input logic          eos_f
);
  // R4
  burst_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_len_o != '0 && mem_len_o <= LW'(MAX_BURST)));

  // R3
  req_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy);

  // R12
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i && !abort_p) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_len_o) && $stable(mem_we_o)));

  // R11
  cnt_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(busy) && !$past(adv)) |-> $stable(cnt));

  // R8
  err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_f) |-> $past(mem_req_o && mem_ack_i && mem_err_i));

  // R5
  eos_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eos_f) |-> (cnt == '0));

  // R7
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_p && busy) |=> (!busy && !mem_req_o && !$rose(eos_f)));
endmodule

bind dma_direct_chan dma_direct_chan_chk #(
  .RW(RW), .CW(CW), .MAX_BURST(MAX_BURST), .LW(LW)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_len_o  (mem_len_o),
  .mem_ack_i  (mem_ack_i),
  .mem_err_i  (mem_err_i),
  .busy       (busy_w),
  .adv        (adv_w),
  .abort_p    (abort_p_w),
  .cnt        (cnt_w),
  .err_f      (err_w),
  .eos_f      (eos_w)
);

// File: tb/tb_dma_direct_chan.sv
module tb_dma_direct_chan;
  localparam logic [2:0] A_MODE = 3'd0, A_STAT = 3'd1, A_SRC = 3'd2, A_DST = 3'd3, A_CNT = 3'd4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o;
  logic [5:0]  mem_len_o;
  logic        mem_ack_i = 1'b0;
  logic        mem_err_i = 1'b0;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  dma_direct_chan dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .mem_req_o(mem_req_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_len_o(mem_len_o),
    .mem_ack_i(mem_ack_i), .mem_err_i(mem_err_i), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    reg_addr_i = a;
    #1;
    chk(tag, reg_rdata_o, exp);
  endtask

  task automatic serve(input string tag, input logic exp_we, input logic [31:0] exp_addr,
                       input logic [5:0] exp_len, input int hold, input logic err);
    for (int w = 0; w < 40 && !mem_req_o; w++) @(negedge clk_i);
    chk({tag, " req"}, 32'(mem_req_o), 32'd1);
    chk({tag, " we"}, 32'(mem_we_o), 32'(exp_we));
    chk({tag, " addr"}, mem_addr_o, exp_addr);
    chk({tag, " len"}, 32'(mem_len_o), 32'(exp_len));
    for (int h = 0; h < hold; h++) begin
      @(negedge clk_i);
      chk({tag, " hold R12"}, {mem_req_o, mem_addr_o[30:0]}, {1'b1, exp_addr[30:0]});
    end
    mem_ack_i = 1'b1; mem_err_i = err;
    @(negedge clk_i);
    mem_ack_i = 1'b0; mem_err_i = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk("R1 mode", A_MODE, 0);
    rd_chk("R1 stat", A_STAT, 0);
    rd_chk("R1 src", A_SRC, 0);
    rd_chk("R1 dst", A_DST, 0);
    rd_chk("R1 cnt", A_CNT, 0);
    chk("R1 req", 32'(mem_req_o), 0);
    chk("R1 irq", 32'(irq_o), 0);
  endtask

  task automatic t_basic;
    wr(A_SRC, 32'h1000); wr(A_DST, 32'h2000); wr(A_CNT, 70);
    wr(A_MODE, 32'h9);
    rd_chk("R3 busy set", A_STAT, 32'h1);
    serve("R4 c0 rd", 0, 32'h1000, 32, 2, 0);
    serve("R4 c0 wr", 1, 32'h2000, 32, 0, 0);
    wr(A_SRC, 32'hdead0000);  // R11
    wr(A_CNT, 5);
    serve("R4 c1 rd", 0, 32'h1020, 32, 0, 0);
    serve("R4 c1 wr", 1, 32'h2020, 32, 0, 0);
    serve("R4 c2 rd", 0, 32'h1040, 6, 0, 0);
    serve("R4 c2 wr", 1, 32'h2040, 6, 0, 0);
    rd_chk("R3 R5 stat done", A_STAT, 32'h4);
    chk("R5 irq", 32'(irq_o), 1);
    rd_chk("R11 src", A_SRC, 32'h1046);
    rd_chk("R4 dst", A_DST, 32'h2046);
    rd_chk("R4 cnt", A_CNT, 0);
    wr(A_STAT, 32'h4);
    rd_chk("R9 eos clr", A_STAT, 0);
    chk("R9 irq clr", 32'(irq_o), 0);
  endtask

  task automatic t_level;
    wr(A_CNT, 8);
    wr(A_MODE, 32'h9);  // start bit already 1
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      chk("R2 no start", 32'(mem_req_o), 0);
    end
    rd_chk("R2 idle", A_STAT, 0);
    wr(A_MODE, 32'h8);
    wr(A_MODE, 32'h9);
    serve("R2 rd", 0, 32'h1046, 8, 0, 0);
    serve("R2 wr", 1, 32'h2046, 8, 0, 0);
    chk("R2 irq", 32'(irq_o), 1);
    wr(A_STAT, 32'h4);
  endtask

  task automatic t_noirq;
    wr(A_MODE, 0); wr(A_CNT, 32); wr(A_MODE, 32'h1);
    serve("R4 full rd", 0, 32'h104e, 32, 0, 0);
    serve("R4 full wr", 1, 32'h204e, 32, 0, 0);
    rd_chk("R5 flag", A_STAT, 32'h4);
    chk("R5 irq gated", 32'(irq_o), 0);
    wr(A_STAT, 32'h4);
  endtask

  task automatic t_zero;
    wr(A_MODE, 0); wr(A_MODE, 32'h1);
    for (int i = 0; i < 3; i++) begin
      chk("R6 no req", 32'(mem_req_o), 0);
      @(negedge clk_i);
    end
    rd_chk("R6 stat", A_STAT, 32'h4);
    wr(A_STAT, 32'h4);
  endtask

  task automatic t_abort;
    wr(A_MODE, 0); wr(A_SRC, 32'h5000); wr(A_DST, 32'h6000); wr(A_CNT, 64);
    wr(A_MODE, 32'h9);
    serve("R7 rd", 0, 32'h5000, 32, 0, 0);
    chk("R7 wr pending", {31'd0, mem_we_o}, 1);
    // abort edge and write ack in the same cycle
    reg_we_i = 1'b1; reg_addr_i = A_MODE; reg_wdata_i = 32'hb; mem_ack_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0; mem_ack_i = 1'b0;
    chk("R7 req drop", 32'(mem_req_o), 0);
    rd_chk("R7 stat", A_STAT, 0);
    chk("R7 irq", 32'(irq_o), 0);
    rd_chk("R7 cnt", A_CNT, 64);
    rd_chk("R7 src", A_SRC, 32'h5000);
  endtask

  task automatic t_error;
    wr(A_MODE, 0); wr(A_SRC, 32'h3000); wr(A_DST, 32'h4000); wr(A_CNT, 40);
    wr(A_MODE, 32'h11);
    serve("R8 rd0", 0, 32'h3000, 32, 0, 0);
    serve("R8 wr0", 1, 32'h4000, 32, 0, 0);
    serve("R8 rd1", 0, 32'h3020, 8, 0, 1);
    rd_chk("R8 stat", A_STAT, 32'ha);
    chk("R8 irq", 32'(irq_o), 1);
    rd_chk("R8 cnt", A_CNT, 8);
    rd_chk("R8 src", A_SRC, 32'h3020);
    wr(A_MODE, 32'h15);
    serve("R10 rd", 0, 32'h3020, 8, 0, 0);
    serve("R10 wr", 1, 32'h4020, 8, 0, 0);
    rd_chk("R10 stat", A_STAT, 32'h6);
    wr(A_STAT, 32'h2);
    rd_chk("R9 err clr", A_STAT, 32'h4);
    chk("R9 irq", 32'(irq_o), 0);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_basic();
    t_level();
    t_noirq();
    t_zero();
    t_abort();
    t_error();
    repeat (2) @(negedge clk_i);
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end
endmodule